// File: doc/BRIEF.md
# Strobe-Synchronized Processor Bus Bridge

This block connects an asynchronous processor bus to a register file that runs on the system clock. The processor starts each bus cycle with a rising strobe. Address, write data and a read/write select come with the strobe. The strobe passes through a synchronizer clocked on the falling clock edge. A detected rising edge then starts a single-clock internal read or write pulse toward the register file.

Reads and writes each have their own cycle engine. Each engine has its own captured address, its own data and its own one-deep pending slot. A write that waits on a buffer that is not ready therefore does not block a read. The register file supplies one status bit per buffer. The low address bits select that bit, and an access to a buffer whose bit is low is held back. A ready output shows the processor, for the kind of cycle it currently selects, when a new strobe may be issued.

Top module: `strobe_bus_bridge`

## Requirements
- R1: While reset is asserted and right after it is released: bus_rdy is 1, reg_wr_en and reg_rd_en are 0, bus_rdata is 0, and no earlier captured cycle is ever issued.
- R2: A strobe that rises before a falling clock edge (setup met) gives its access pulse (reg_wr_en when bus_rd=0, reg_rd_en when bus_rd=1) at the 2nd rising clock edge after the strobe rise, provided the addressed buffer is ready.
- R3: A strobe that rises just after a falling clock edge (setup missed) gives its access pulse at the 3rd rising clock edge after the strobe rise. This is exactly one clock period later than R2.
- R4: Each access pulse lasts exactly one clock. For the kind selected by bus_rd, bus_rdy is 0 while that kind's cycle is captured or being accessed, and it is 1 again on the clock after the pulse.
- R5: A write presents the address and write data that were present on the bus when the strobe was captured on reg_wr_addr/reg_wr_data. Writes appear in the order of their strobes.
- R6: A read returns the register file's data at reg_rd_addr on bus_rdata one clock after reg_rd_en. bus_rdata then holds that value until the next read, including across writes.
- R7: The buffer index is address bits [log2(NBUF)-1:0]. While buf_status at that index is 0, the access is held back and bus_rdy for that kind stays 0. The access is issued once the bit returns to 1.
- R8: Read and write paths are separate. A read completes with R2 latency while a write is being held back by R7, and bus_rdy with bus_rd=1 does not depend on the write path.
- R9: A second strobe of the same kind that arrives while the first is still held back is kept in a one-deep pending slot, not lost. It is issued after the first.
- R10: Asserting reset while a cycle is held back discards that cycle. No access pulse follows once status becomes ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobe sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_stb | input | 1 | Asynchronous bus strobe; a rising edge starts a cycle |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | input | AW | Bus address |
| bus_wdata | input | DW | Bus write data |
| bus_rdata | output | DW | Last read data, held until the next read |
| bus_rdy | output | 1 | Ready for a new cycle of the kind selected by bus_rd |
| buf_status | input | NBUF | Per-buffer ready bits from the register file |
| reg_wr_en | output | 1 | One-clock write pulse to the register file |
| reg_wr_addr | output | AW | Write address |
| reg_wr_data | output | DW | Write data |
| reg_rd_en | output | 1 | One-clock read pulse to the register file |
| reg_rd_addr | output | AW | Read address |
| reg_rd_data | input | DW | Register file read data for reg_rd_addr |

## Verification
The assertions rely on a few conditions on the inputs. The processor holds bus_rd, bus_addr and bus_wdata steady from the strobe's rise until the cycle has been captured. Each strobe stays high and then low for at least a clock period. No third strobe of a kind arrives while both the active and the pending slot of that kind are occupied. The stimulus keeps the strobe high for three periods and low for one. It changes the select and the data only while the strobe is low. It issues at most two same-kind strobes into a stalled buffer before releasing its status bit. The register file read data is modelled as combinational on reg_rd_addr.

// File: rtl/bus_bridge_pkg.sv
package bus_bridge_pkg;

  typedef enum logic {
    ACC_WRITE = 1'b0,
    ACC_READ  = 1'b1
  } acc_kind_e;

  // bits needed to index n buffers (at least one)
  function automatic int idx_bits(input int n);
    int b;
    b = 1;
    while ((1 << b) < n) b++;
    return b;
  endfunction

endpackage

// File: rtl/bridge_strobe_sync.sv
module bridge_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_in};
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

  // a detected edge lasts exactly one falling-edge interval
  p_rise_single_r2: assert property (@(negedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/bridge_cycle_engine.sv
module bridge_cycle_engine #(
  parameter int PW   = 6,
  parameter int NBUF = 4,
  parameter int AOFF = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [PW-1:0]   start_pl,
  input  logic [NBUF-1:0] buf_status,
  output logic            acc_en,
  output logic [PW-1:0]   acc_pl,
  output logic            busy
);

  localparam int BIW = bus_bridge_pkg::idx_bits(NBUF);

  logic          act_v,  act_v_d;
  logic [PW-1:0] act_pl, act_pl_d;
  logic          pend_v, pend_v_d;
  logic [PW-1:0] pend_pl, pend_pl_d;
  logic          acc_q;
  logic [PW-1:0] acc_pl_q;

  logic          head_v;
  logic [PW-1:0] head_pl;
  logic [BIW-1:0] head_idx;
  logic          head_ok;
  logic          go;

  always_comb begin
    head_v   = act_v | start;
    head_pl  = act_v ? act_pl : start_pl;
    head_idx = head_pl[AOFF +: BIW];
    head_ok  = buf_status[head_idx];
    go       = head_v & head_ok & ~acc_q;
  end

  // next-state for the captured / pending slots
  always_comb begin
    act_v_d   = act_v;
    act_pl_d  = act_pl;
    pend_v_d  = pend_v;
    pend_pl_d = pend_pl;
    if (go) begin
      if (act_v) begin
        if (pend_v) begin
          act_pl_d  = pend_pl;
          pend_v_d  = start;
          pend_pl_d = start ? start_pl : pend_pl;
        end else begin
          act_v_d  = start;
          act_pl_d = start ? start_pl : act_pl;
        end
      end
    end else if (start) begin
      if (!act_v) begin
        act_v_d  = 1'b1;
        act_pl_d = start_pl;
      end else if (!pend_v) begin
        pend_v_d  = 1'b1;
        pend_pl_d = start_pl;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_v    <= 1'b0;
      act_pl   <= '0;
      pend_v   <= 1'b0;
      pend_pl  <= '0;
      acc_q    <= 1'b0;
      acc_pl_q <= '0;
    end else begin
      act_v   <= act_v_d;
      act_pl  <= act_pl_d;
      pend_v  <= pend_v_d;
      pend_pl <= pend_pl_d;
      acc_q   <= go;
      if (go) acc_pl_q <= head_pl;
    end
  end

  assign acc_en = acc_q;
  assign acc_pl = acc_pl_q;
  assign busy   = act_v | pend_v | acc_q;

  p_pulse_one_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |=> !acc_q);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !pend_v);

  p_issue_when_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> $past(head_ok));

endmodule

// File: rtl/strobe_bus_bridge.sv
module strobe_bus_bridge #(
  parameter int AW          = 6,
  parameter int DW          = 8,
  parameter int NBUF        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_stb,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_rdy,
  input  logic [NBUF-1:0] buf_status,
  output logic            reg_wr_en,
  output logic [AW-1:0]   reg_wr_addr,
  output logic [DW-1:0]   reg_wr_data,
  output logic            reg_rd_en,
  output logic [AW-1:0]   reg_rd_addr,
  input  logic [DW-1:0]   reg_rd_data
);
  import bus_bridge_pkg::*;

  localparam int WPW = AW + DW;

  logic           stb_rise;
  logic           rd_start, wr_start;
  logic           rd_busy, wr_busy;
  logic [WPW-1:0] wr_pl;
  logic [DW-1:0]  rdata_q;
  acc_kind_e      kind;

  bridge_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(bus_stb), .rise(stb_rise)
  );

  assign kind     = bus_rd ? ACC_READ : ACC_WRITE;
  assign rd_start = stb_rise & (kind == ACC_READ);
  assign wr_start = stb_rise & (kind == ACC_WRITE);

  bridge_cycle_engine #(.PW(AW), .NBUF(NBUF), .AOFF(0)) u_rd (
    .clk(clk), .rst_n(rst_n), .start(rd_start), .start_pl(bus_addr),
    .buf_status(buf_status), .acc_en(reg_rd_en), .acc_pl(reg_rd_addr),
    .busy(rd_busy)
  );

  bridge_cycle_engine #(.PW(WPW), .NBUF(NBUF), .AOFF(DW)) u_wr (
    .clk(clk), .rst_n(rst_n), .start(wr_start), .start_pl({bus_addr, bus_wdata}),
    .buf_status(buf_status), .acc_en(reg_wr_en), .acc_pl(wr_pl),
    .busy(wr_busy)
  );

  assign reg_wr_addr = wr_pl[DW +: AW];
  assign reg_wr_data = wr_pl[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_q <= '0;
    else if (reg_rd_en) rdata_q <= reg_rd_data;
  end

  assign bus_rdata = rdata_q;
  assign bus_rdy   = (kind == ACC_READ) ? ~(rd_busy | rd_start)
                                        : ~(wr_busy | wr_start);

  p_rdy_low_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !bus_rd) |-> !bus_rdy);

  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> $stable(bus_rdata));

endmodule

// File: tb/tb_strobe_bus_bridge.sv
`timescale 1ns/100ps
module tb_strobe_bus_bridge;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int NBUF = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_stb, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata, reg_wr_data, reg_rd_data;
  logic bus_rdy, reg_wr_en, reg_rd_en;
  logic [AW-1:0] reg_wr_addr, reg_rd_addr;
  logic [NBUF-1:0] buf_status;
  logic [DW-1:0] mem [64];

  int checks = 0, errors = 0, wr_seen = 0, rd_seen = 0;
  logic [AW+DW-1:0] wr_exp[$];
  logic [DW-1:0]    rd_exp[$];

  always #2.5 clk = ~clk;

  strobe_bus_bridge #(.AW(AW), .DW(DW), .NBUF(NBUF)) dut (
    .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdy(bus_rdy), .buf_status(buf_status), .reg_wr_en(reg_wr_en),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
  );

  assign reg_rd_data = mem[reg_rd_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  initial begin
    bit rd_due = 0;
    logic [AW+DW-1:0] w;
    logic [DW-1:0] r;
    forever begin
      @(posedge clk); #1;
      if (rd_due) begin
        if (rd_exp.size() == 0) chk(0, "R6 unexpected read", 1, 0);
        else begin
          r = rd_exp.pop_front();
          chk(bus_rdata == r, "R6 read data", int'(bus_rdata), int'(r));
        end
        rd_due = 0;
      end
      if (reg_rd_en) begin rd_due = 1; rd_seen++; end
      if (reg_wr_en) begin
        wr_seen++;
        if (wr_exp.size() == 0) chk(0, "R10 unexpected write", int'(reg_wr_addr), -1);
        else begin
          w = wr_exp.pop_front();
          chk({reg_wr_addr, reg_wr_data} == w, "R5 write addr/data",
              int'({reg_wr_addr, reg_wr_data}), int'(w));
        end
      end
    end
  end

  task automatic timed_cycle(input bit rd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input bit met, input int exp_lat, input string req);
    int lat = 0;
    bit hit = 0;
    @(negedge clk);
    if (met) #4; else #0.5;
    bus_rd = rd; bus_addr = a; bus_wdata = d; bus_stb = 1'b1;
    if (rd) rd_exp.push_back(mem[a]); else wr_exp.push_back({a, d});
    for (int k = 0; k < 12 && !hit; k++) begin
      @(posedge clk); lat++; #1;
      hit = rd ? reg_rd_en : reg_wr_en;
    end
    chk(hit && lat == exp_lat, req, lat, exp_lat);
    chk(bus_rdy == 1'b0, "R4 rdy low during access", int'(bus_rdy), 0);
    bus_stb = 1'b0;
    @(posedge clk); #1;
    chk((rd ? reg_rd_en : reg_wr_en) == 1'b0 && bus_rdy == 1'b1,
        "R4 pulse ends, rdy back", int'(bus_rdy), 1);
  endtask

  task automatic raise_only(input bit rd, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); #1;
    bus_rd = rd; bus_addr = a; bus_wdata = d; bus_stb = 1'b1;
    if (rd) rd_exp.push_back(mem[a]); else wr_exp.push_back({a, d});
    #15 bus_stb = 1'b0;
    #5;
  endtask

  initial begin
    #1000000;
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int snap;
    logic [DW-1:0] last_rd;
    for (int i = 0; i < 64; i++) mem[i] = DW'(i * 7 + 3);
    rst_n = 1'b0; bus_stb = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    buf_status = '1;
    repeat (4) @(posedge clk);
    #1;
    chk(bus_rdy == 1 && reg_wr_en == 0 && reg_rd_en == 0, "R1 reset outputs", int'(bus_rdy), 1);
    chk(bus_rdata == 0, "R1 reset rdata", int'(bus_rdata), 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk(bus_rdy == 1 && reg_wr_en == 0, "R1 after release", int'(bus_rdy), 1);

    // R2 / R3 latency, both kinds
    timed_cycle(0, 6'h11, 8'hA5, 1, 2, "R2 write setup met");
    timed_cycle(0, 6'h22, 8'h3C, 0, 3, "R3 write setup missed");
    timed_cycle(1, 6'h07, 8'h00, 1, 2, "R2 read setup met");
    timed_cycle(1, 6'h2D, 8'h00, 0, 3, "R3 read setup missed");
    repeat (2) @(posedge clk);
    last_rd = mem[6'h2D];

    // R6 hold across a write
    timed_cycle(0, 6'h30, 8'h5A, 1, 2, "R2 write before hold check");
    #1;
    chk(bus_rdata == last_rd, "R6 rdata held across write", int'(bus_rdata), int'(last_rd));

    // R7 stall on buffer 2, R8 read overlaps
    buf_status = 4'b1011;
    snap = wr_seen;
    raise_only(0, 6'h0A, 8'h77);
    repeat (6) @(posedge clk);
    #1;
    chk(wr_seen == snap, "R7 write held", wr_seen, snap);
    chk(bus_rdy == 0, "R7 rdy low while held", int'(bus_rdy), 0);
    timed_cycle(1, 6'h05, 8'h00, 1, 2, "R8 read during stalled write");
    repeat (2) @(posedge clk);
    #1;
    chk(bus_rdy == 1, "R8 read-side rdy independent", int'(bus_rdy), 1);
    bus_rd = 0; #1;
    chk(bus_rdy == 0 && wr_seen == snap, "R7 write still held", int'(bus_rdy), 0);
    buf_status = 4'b1111;
    repeat (4) @(posedge clk);
    #1;
    chk(wr_seen == snap + 1, "R7 write issued on status", wr_seen, snap + 1);
    chk(bus_rdy == 1, "R7 rdy restored", int'(bus_rdy), 1);

    // R9 pending slot
    buf_status = 4'b0111;
    snap = wr_seen;
    raise_only(0, 6'h0B, 8'h11);
    raise_only(0, 6'h0F, 8'h22);
    repeat (2) @(posedge clk);
    #1;
    chk(wr_seen == snap, "R9 both held", wr_seen, snap);
    buf_status = 4'b1111;
    repeat (8) @(posedge clk);
    #1;
    chk(wr_seen == snap + 2, "R9 both issued", wr_seen, snap + 2);
    chk(bus_rdy == 1, "R9 rdy after drain", int'(bus_rdy), 1);

    // R10 reset discards held cycle
    buf_status = 4'b1101;
    snap = wr_seen;
    raise_only(0, 6'h01, 8'h99);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b0;
    wr_exp.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    buf_status = 4'b1111;
    repeat (8) @(posedge clk);
    #1;
    chk(wr_seen == snap, "R10 no write after reset", wr_seen, snap);
    chk(bus_rdy == 1 && bus_rdata == 0, "R10 rdy/rdata after reset", int'(bus_rdata), 0);

    chk(wr_exp.size() == 0 && rd_exp.size() == 0, "R5 scoreboard drained",
        wr_exp.size() + rd_exp.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule